// File: doc/BRIEF.md
# Four-Level Priority Interrupt Controller

The block watches 82 interrupt request lines and chooses which of them the processor core should service next. Software gives each line one of four priority levels through a small byte-wide register bus. Level 3 is the most urgent and level 0 the least. Two lines are hard-wired to level 3 and cannot be reprogrammed. The controller first finds the most urgent level that has an active line. Within that level, the line with the lowest index wins.

The core supplies a two-bit mask that states the lowest level it will accept. Only levels at or above that value are admitted, so an interrupt can nest over the one in service only when its level is higher. When a request is admitted, the block raises a request to the core together with a vector address. The address is a 16-bit base register with the 7-bit number of the winning line appended. The request and vector stay unchanged until the core pulses an acknowledge. A wake output goes high whenever some admitted request is pending, so that stopped clocks can be started again.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, every programmable level field reads 0, the base register reads 0, `int_req` is 0 and `int_vec_addr` is 0.
- R2: Register k (k = 0..20) holds the levels of lines 4k..4k+3. Line 4k+j occupies bits [2j+1:2j]. Writes to these fields take effect at the clock edge and read back unchanged. Bit pairs for line numbers 82 and 83 read 0.
- R3: Lines 0 and 1 always read as level 3, and writes to their fields are ignored.
- R4: Among active lines of the same level, the line with the lowest index is selected.
- R5: Across levels, the highest admitted level that has any active line is selected, whatever the line indices are.
- R6: With mask value m on `core_mask`, a level L is admitted only when L >= m. So 00 admits all levels, 01 admits levels 1 to 3, 10 admits levels 2 and 3, and 11 admits only level 3.
- R7: The vector address is {base[15:0], line[6:0]}. The low byte of the base is at register address 21 and the high byte at register address 22.
- R8: When an admitted request is pending while no request is outstanding, `int_req` rises at the next clock edge with the vector of that request. Until an acknowledge, both stay unchanged, even if a more urgent line becomes active.
- R9: An `int_ack` while `int_req` is high makes `int_req` fall for exactly one cycle with the vector unchanged. Arbitration then runs again. An acknowledge while `int_req` is low has no effect.
- R10: `wake_out` is high in the same cycle whenever at least one active line has an admitted level, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (combinational) |
| irq_lines | input | 82 | Interrupt request lines, bit n is line n |
| core_mask | input | 2 | Core's current interrupt mask |
| int_ack | input | 1 | Acknowledge pulse from the core |
| int_req | output | 1 | Interrupt request to the core |
| int_vec_addr | output | 23 | Vector address {base, line number} |
| wake_out | output | 1 | Admitted interrupt pending |

## Verification
On every cycle, assertions check the following:
- An encoder's chosen line really is active at its level.
- A selected winner never falls below the core mask.
- The request and vector hold until acknowledge.
- An acknowledge produces a one-cycle drop with the vector frozen.
- Every new request was preceded by a wake indication and carries the base and line that were current when it was taken.

Only the directed scenarios can show the following:
- The register packing and readback.
- The immunity of the fixed lines to writes.
- That the lowest index wins inside a level and the highest level wins across levels.
- The full four-value mask table.
- That a more urgent line arriving mid-request is deferred until after the acknowledge.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int LVL_W      = 2;
    localparam int NUM_LVL    = 1 << LVL_W;
    localparam int DEF_SRC    = 82;
    localparam int SRC_W      = $clog2(DEF_SRC);
    localparam int DEF_BASE_W = 16;
    localparam int DATA_W     = 8;
    localparam int FIXED_LVL  = NUM_LVL - 1;

    typedef logic [LVL_W-1:0] level_t;

    typedef struct packed {
        logic             valid;
        logic [SRC_W-1:0] src;
        level_t           lvl;
    } win_t;

    typedef enum logic [0:0] {
        HS_IDLE = 1'b0,
        HS_REQ  = 1'b1
    } hs_state_t;

    function automatic logic level_admitted(input level_t lvl, input level_t mask);
        return lvl >= mask;
    endfunction

endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
    import irq_prio_pkg::*;
#(
    parameter int NUM_SRC   = DEF_SRC,
    parameter int NUM_FIXED = 2,
    parameter int BASE_W    = DEF_BASE_W,
    parameter int ADDR_W    = 5
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    output logic [DATA_W-1:0]             rdata,
    output logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl,
    output logic [BASE_W-1:0]             base
);

    localparam int FPR        = DATA_W / LVL_W;
    localparam int NREG       = (NUM_SRC + FPR - 1) / FPR;
    localparam int BASE_BYTES = (BASE_W + DATA_W - 1) / DATA_W;

    logic [BASE_BYTES-1:0][DATA_W-1:0] base_q;
    logic [BASE_BYTES*DATA_W-1:0]      base_flat;

    // per-source level fields: fixed ones are constants, others are flops
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_field
        if (i < NUM_FIXED) begin : g_fixed
            assign src_lvl[i] = LVL_W'(FIXED_LVL);
        end else begin : g_prog
            always_ff @(posedge clk) begin
                if (rst) begin
                    src_lvl[i] <= '0;
                end else if (we && addr == ADDR_W'(i / FPR)) begin
                    src_lvl[i] <= wdata[(i % FPR)*LVL_W +: LVL_W];
                end
            end
        end
    end

    for (genvar b = 0; b < BASE_BYTES; b++) begin : g_base
        always_ff @(posedge clk) begin
            if (rst) begin
                base_q[b] <= '0;
            end else if (we && addr == ADDR_W'(NREG + b)) begin
                base_q[b] <= wdata;
            end
        end
    end

    assign base_flat = base_q;
    assign base      = base_flat[BASE_W-1:0];

    always_comb begin
        rdata = '0;
        if (int'(addr) < NREG) begin
            for (int f = 0; f < FPR; f++) begin
                if (int'(addr) * FPR + f < NUM_SRC) begin
                    rdata[f*LVL_W +: LVL_W] = src_lvl[int'(addr) * FPR + f];
                end
            end
        end else if (int'(addr) < NREG + BASE_BYTES) begin
            rdata = base_q[int'(addr) - NREG];
        end
    end

endmodule

// File: rtl/irq_level_enc.sv
module irq_level_enc
    import irq_prio_pkg::*;
#(
    parameter int NUM_SRC = DEF_SRC,
    parameter int LEVEL   = 0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_SRC-1:0]            irq,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl,
    output logic                          hit,
    output logic [SRC_W-1:0]              idx
);

    // lowest index at this level wins: scan from the top down
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (irq[i] && src_lvl[i] == LVL_W'(LEVEL)) begin
                hit = 1'b1;
                idx = SRC_W'(i);
            end
        end
    end

    // R4
    enc_pick_valid_chk: assert property (@(posedge clk) disable iff (rst)
        hit |-> (irq[idx] && src_lvl[idx] == LVL_W'(LEVEL)));

endmodule

// File: rtl/irq_level_pick.sv
module irq_level_pick
    import irq_prio_pkg::*;
#(
    parameter int NUM_SRC = DEF_SRC
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_SRC-1:0]            irq,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl,
    input  level_t                        mask,
    output win_t                          win
);

    logic [NUM_LVL-1:0]            hit;
    logic [NUM_LVL-1:0][SRC_W-1:0] idx;

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        irq_level_enc #(
            .NUM_SRC (NUM_SRC),
            .LEVEL   (l)
        ) u_enc (
            .clk     (clk),
            .rst     (rst),
            .irq     (irq),
            .src_lvl (src_lvl),
            .hit     (hit[l]),
            .idx     (idx[l])
        );
    end

    always_comb begin
        win = '0;
        for (int l = NUM_LVL - 1; l >= 0; l--) begin
            if (!win.valid && hit[l] && level_admitted(LVL_W'(l), mask)) begin
                win.valid = 1'b1;
                win.src   = idx[l];
                win.lvl   = LVL_W'(l);
            end
        end
    end

    // R5
    top_level_first_chk: assert property (@(posedge clk) disable iff (rst)
        hit[NUM_LVL-1] |-> (win.valid && win.lvl == LVL_W'(NUM_LVL-1)));

endmodule

// File: rtl/irq_req_fsm.sv
module irq_req_fsm
    import irq_prio_pkg::*;
#(
    parameter int BASE_W = DEF_BASE_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cand_valid,
    input  logic [SRC_W-1:0]        cand_src,
    input  logic [BASE_W-1:0]       base,
    input  logic                    ack,
    output logic                    req,
    output logic [BASE_W+SRC_W-1:0] vec
);

    hs_state_t state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= HS_IDLE;
            vec     <= '0;
        end else begin
            case (state_q)
                HS_IDLE: begin
                    if (cand_valid) begin
                        state_q <= HS_REQ;
                        vec     <= {base, cand_src};
                    end
                end
                HS_REQ: begin
                    if (ack) begin
                        state_q <= HS_IDLE;
                    end
                end
                default: state_q <= HS_IDLE;
            endcase
        end
    end

    assign req = (state_q == HS_REQ);

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !ack) |=> (req && $stable(vec)));

    // R9
    ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (req && ack) |=> (!req && $stable(vec)));

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int NUM_SRC   = DEF_SRC,
    parameter int NUM_FIXED = 2,
    parameter int BASE_W    = DEF_BASE_W,
    parameter int ADDR_W    = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [ADDR_W-1:0]       cfg_addr,
    input  logic [DATA_W-1:0]       cfg_wdata,
    output logic [DATA_W-1:0]       cfg_rdata,
    input  logic [NUM_SRC-1:0]      irq_lines,
    input  logic [LVL_W-1:0]        core_mask,
    input  logic                    int_ack,
    output logic                    int_req,
    output logic [BASE_W+SRC_W-1:0] int_vec_addr,
    output logic                    wake_out
);

    logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl;
    logic [BASE_W-1:0]             base;
    win_t                          win;

    irq_prio_regs #(
        .NUM_SRC   (NUM_SRC),
        .NUM_FIXED (NUM_FIXED),
        .BASE_W    (BASE_W),
        .ADDR_W    (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .src_lvl (src_lvl),
        .base    (base)
    );

    irq_level_pick #(
        .NUM_SRC (NUM_SRC)
    ) u_pick (
        .clk     (clk),
        .rst     (rst),
        .irq     (irq_lines),
        .src_lvl (src_lvl),
        .mask    (core_mask),
        .win     (win)
    );

    irq_req_fsm #(
        .BASE_W (BASE_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cand_valid (win.valid),
        .cand_src   (win.src),
        .base       (base),
        .ack        (int_ack),
        .req        (int_req),
        .vec        (int_vec_addr)
    );

    assign wake_out = win.valid;

    // R6
    mask_gate_chk: assert property (@(posedge clk) disable iff (rst)
        win.valid |-> (win.lvl >= core_mask));

    // R7
    vec_form_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(int_req) |-> (int_vec_addr == {$past(base), $past(win.src)}));

    // R10
    wake_before_req_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(int_req) |-> $past(wake_out));

endmodule

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [4:0]  cfg_addr;
    logic [7:0]  cfg_wdata;
    logic [7:0]  cfg_rdata;
    logic [81:0] irq_lines;
    logic [1:0]  core_mask;
    logic        int_ack;
    logic        int_req;
    logic [22:0] int_vec_addr;
    logic        wake_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [15:0] base_exp = 16'h0000;

    always #2.5 clk = ~clk;

    irq_prio_ctrl dut (
        .clk          (clk),
        .rst          (rst),
        .cfg_we       (cfg_we),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .irq_lines    (irq_lines),
        .core_mask    (core_mask),
        .int_ack      (int_ack),
        .int_req      (int_req),
        .int_vec_addr (int_vec_addr),
        .wake_out     (wake_out)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic read_reg(input logic [4:0] a, output logic [7:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic set_level(input int src, input logic [1:0] lvl);
        logic [7:0] cur;
        read_reg(5'(src / 4), cur);
        cur[(src % 4)*2 +: 2] = lvl;
        write_reg(5'(src / 4), cur);
    endtask

    // drive lines and mask from idle, check wake, request, vector, then ack and clear
    task automatic run_irq(input logic [81:0] lines, input logic [1:0] m,
                           input bit exp_v, input int exp_src, input string tag);
        logic [22:0] exp_vec;
        exp_vec = {base_exp, 7'(exp_src)};
        @(negedge clk);
        irq_lines = lines; core_mask = m;
        #1;
        check(wake_out == exp_v, {tag, " wake R10"}, 32'(wake_out), 32'(exp_v));
        @(negedge clk);
        check(int_req == exp_v, {tag, " req"}, 32'(int_req), 32'(exp_v));
        if (exp_v) begin
            check(int_vec_addr == exp_vec, {tag, " vector"}, 32'(int_vec_addr), 32'(exp_vec));
            int_ack = 1'b1;
            irq_lines = '0;
            @(negedge clk);
            int_ack = 1'b0;
            check(int_req == 1'b0, {tag, " ack drop R9"}, 32'(int_req), 32'd0);
        end
        irq_lines = '0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check(int_req == 1'b0, "R1 req", 32'(int_req), 32'd0);
        check(int_vec_addr == '0, "R1 vector", 32'(int_vec_addr), 32'd0);
        check(wake_out == 1'b0, "R1 wake", 32'(wake_out), 32'd0);
        for (int k = 1; k < 21; k++) begin
            read_reg(5'(k), d);
            check(d == 8'h00, "R1 level reg", 32'(d), 32'd0);
        end
        read_reg(5'd21, d); check(d == 8'h00, "R1 base lo", 32'(d), 32'd0);
        read_reg(5'd22, d); check(d == 8'h00, "R1 base hi", 32'(d), 32'd0);
    endtask

    task automatic t_fields();
        logic [7:0] d;
        write_reg(5'd5, 8'hE4);
        read_reg(5'd5, d);
        check(d == 8'hE4, "R2 readback reg5", 32'(d), 32'hE4);
        write_reg(5'd20, 8'hFF);
        read_reg(5'd20, d);
        check(d == 8'h0F, "R2 reg20 upper pairs zero", 32'(d), 32'h0F);
        write_reg(5'd5, 8'h00);
        write_reg(5'd20, 8'h00);
    endtask

    task automatic t_fixed();
        logic [7:0] d;
        read_reg(5'd0, d);
        check(d == 8'h0F, "R3 fixed after reset", 32'(d), 32'h0F);
        write_reg(5'd0, 8'hF0);
        read_reg(5'd0, d);
        check(d == 8'hFF, "R3 fixed ignore write", 32'(d), 32'hFF);
        write_reg(5'd0, 8'h00);
        read_reg(5'd0, d);
        check(d == 8'h0F, "R3 fixed ignore clear", 32'(d), 32'h0F);
    endtask

    task automatic t_base();
        write_reg(5'd21, 8'hCD);
        write_reg(5'd22, 8'hAB);
        base_exp = 16'hABCD;
        run_irq(82'(1) << 33, 2'd0, 1'b1, 33, "R7 base concat");
    endtask

    task automatic t_within();
        logic [81:0] l;
        set_level(10, 2'd1); set_level(20, 2'd1); set_level(30, 2'd1);
        l = (82'(1) << 30) | (82'(1) << 20);
        run_irq(l, 2'd0, 1'b1, 20, "R4 lowest index");
        l = (82'(1) << 30) | (82'(1) << 20) | (82'(1) << 10) | (82'(1) << 81);
        run_irq(l, 2'd0, 1'b1, 10, "R4 lowest index b");
        run_irq(82'(1) << 81, 2'd0, 1'b1, 81, "R4 last line");
    endtask

    task automatic t_across();
        logic [81:0] l;
        set_level(60, 2'd1); set_level(70, 2'd2);
        l = (82'(1) << 60) | (82'(1) << 70) | (82'(1) << 2);
        run_irq(l, 2'd0, 1'b1, 70, "R5 higher level wins");
        run_irq(l | 82'(1) << 1, 2'd0, 1'b1, 1, "R5 fixed level 3 wins");
    endtask

    task automatic t_mask();
        set_level(40, 2'd1);
        for (int m = 0; m < 4; m++) begin
            run_irq(82'(1) << 40, 2'(m), m <= 1, 40, "R6 level1 line");
            run_irq(82'(1) << 50, 2'(m), m == 0, 50, "R6 level0 line");
            run_irq(82'(1) << 70, 2'(m), m <= 2, 70, "R6 level2 line");
            run_irq(82'(1) << 0,  2'(m), 1'b1,   0,  "R6 level3 line");
        end
    endtask

    task automatic t_handshake();
        logic [22:0] v5, v3;
        set_level(5, 2'd2); set_level(3, 2'd2);
        v5 = {base_exp, 7'd5};
        v3 = {base_exp, 7'd3};
        @(negedge clk);
        irq_lines = 82'(1) << 5; core_mask = 2'd0;
        @(negedge clk);
        check(int_req == 1'b1, "R8 req rises", 32'(int_req), 32'd1);
        irq_lines = irq_lines | (82'(1) << 3) | (82'(1) << 1);
        repeat (3) begin
            @(negedge clk);
            check(int_req == 1'b1, "R8 req held", 32'(int_req), 32'd1);
            check(int_vec_addr == v5, "R8 vector held", 32'(int_vec_addr), 32'(v5));
        end
        irq_lines = (82'(1) << 5) | (82'(1) << 3);
        int_ack = 1'b1;
        @(negedge clk);
        int_ack = 1'b0;
        check(int_req == 1'b0, "R9 one-cycle drop", 32'(int_req), 32'd0);
        check(int_vec_addr == v5, "R9 vector kept", 32'(int_vec_addr), 32'(v5));
        @(negedge clk);
        check(int_req == 1'b1, "R9 rearbitrate", 32'(int_req), 32'd1);
        check(int_vec_addr == v3, "R9 new winner", 32'(int_vec_addr), 32'(v3));
        int_ack = 1'b1; irq_lines = '0;
        @(negedge clk);
        int_ack = 1'b0;
        // ack while idle: no effect
        int_ack = 1'b1;
        @(negedge clk);
        int_ack = 1'b0;
        check(int_req == 1'b0, "R9 idle ack ignored", 32'(int_req), 32'd0);
        check(int_vec_addr == v3, "R9 idle ack vector", 32'(int_vec_addr), 32'(v3));
        irq_lines = 82'(1) << 5;
        @(negedge clk);
        check(int_req == 1'b1, "R9 after idle ack", 32'(int_req), 32'd1);
        check(int_vec_addr == v5, "R9 after idle ack vector", 32'(int_vec_addr), 32'(v5));
        int_ack = 1'b1; irq_lines = '0;
        @(negedge clk);
        int_ack = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        irq_lines = '0; core_mask = '0; int_ack = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fields();
        t_fixed();
        t_base();
        t_within();
        t_across();
        t_mask();
        t_handshake();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule